// File: doc/BRIEF.md
# GF(4096) Tower-Field Multiplier with Power Stepper

This block multiplies two 12-bit elements of GF(4096), the symbol field of a 12-bit Reed-Solomon code. The field is a quadratic extension of GF(64). Each operand is a pair of 6-bit halves (high, low), read as high·X + low. The extension polynomial is X² + X + A⁻¹, and GF(64) itself is reduced modulo x⁶ + x + 1. The product is built from four GF(64) sub-multipliers. One of them scales the high-by-high term by the fixed GF(64) constant 0x21. The result is registered once.

A second path walks the powers of the field constant 0xE01. A start pulse loads the element 1 with index 0. Each enabled clock then multiplies the current element by 0xE01, advances the index, and raises a valid strobe. Hardware can use this to fill exponent and logarithm tables, one entry per clock. Because 0xE01 generates the whole multiplicative group, the walk comes back to 1 after 4095 steps. At that point it flags a wrap and the index restarts at 0. The two paths are independent and can work in the same cycle.

Top module: `gf_tower_mul`

## Requirements
- R1: While reset is asserted, product reads 0, prodValid 0, powValue 1 (0x001), powIndex 0, and powValid and powWrap 0.
- R2: For operands a = {ah, al} and b = {bh, bl}, each half 6 bits with bit 11..6 the high half, the product is {(ah⊕al)·(bh⊕bl) ⊕ al·bl, (ah·bh)·0x21 ⊕ al·bl}. Each · is a GF(64) product reduced modulo x⁶ + x + 1.
- R3: The product appears one clock after the cycle in which mulValid is high, with prodValid high in that same cycle. When mulValid is low, prodValid drops and product keeps its last value.
- R4: A zero operand on either side gives a zero product.
- R5: The element 0x001 is the multiplicative identity, and swapping the operands never changes the product.
- R6: seqStart loads powValue = 0x001 and powIndex = 0 one clock later, with powValid high. seqStart wins over seqEnable in the same cycle.
- R7: Each clock with seqEnable high and seqStart low multiplies powValue by 0xE01 and raises powIndex by one, with powValid high. The first step from 0x001 gives 0xE01, and powValue is never zero.
- R8: With seqStart and seqEnable both low, powValue and powIndex hold, and powValid and powWrap stay low.
- R9: Starting from 0x001, the walk does not meet 0x001 again during steps 1 to 4094. At step 4095 it returns to 0x001, and powIndex becomes 0 with powWrap high for that one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mulValid | input | 1 | Capture a product of opA and opB this cycle |
| opA | input | 12 | First field operand |
| opB | input | 12 | Second field operand |
| product | output | 12 | Registered field product |
| prodValid | output | 1 | product was updated by the last clock |
| seqStart | input | 1 | Restart the power walk at element 1 |
| seqEnable | input | 1 | Advance the power walk by one step |
| powValue | output | 12 | Current power of 0xE01 |
| powIndex | output | 12 | Exponent of powValue, 0 to 4094 |
| powValid | output | 1 | powValue/powIndex were loaded or advanced by the last clock |
| powWrap | output | 1 | Walk has just returned to element 1 |

## Verification
Operand patterns of several kinds are used, and each one isolates a different part of the product:
- Pure-low operands exercise only the GF(64) reduction.
- Pure-high operands such as 0x040·0x040 must give 0x061, which isolates the 0x21 cross-term scaling.
- Zero and identity operands catch a wrong absorbing element or a wrong neutral element.
- Swapped random pairs expose any asymmetry between the sum-of-halves and low-by-low sub-products.
- Back-to-back random pairs catch a stale or held operand.

The power walk is run with gaps, with a start and an enable raised together, and once for a full 4095 steps. The full run is where a wrong step constant or a wrong wrap index shows up as an early return to 1 or a missing wrap.

// File: rtl/gf_tower_pkg.sv
package gf_tower_pkg;

  // Strobes issued by the control unit to the datapath each cycle.
  typedef struct packed {
    logic mulLoad;   // capture a new operand product
    logic seqLoad;   // reload the power walk with element 1
    logic seqStep;   // multiply the walk by the step constant
  } tower_ctl_t;

endpackage

// File: rtl/gf_sub_mul.sv
// Combinational multiplier in GF(2^W), polynomial basis.
// POLY holds the reduction polynomial without its x^W term.
module gf_sub_mul #(
  parameter int unsigned W = 6,
  parameter logic [W-1:0] POLY = 6'h03
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] p
);

  // shifted[i] = a * x^i reduced; partial[i] = sum over bits of b below i
  logic [W-1:0] shifted [0:W-1];
  logic [W-1:0] partial [0:W];

  assign shifted[0] = a;
  assign partial[0] = '0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign partial[i+1] = partial[i] ^ ({W{b[i]}} & shifted[i]);
    if (i < W - 1) begin : g_shift
      assign shifted[i+1] = {shifted[i][W-2:0], 1'b0}
                          ^ ({W{shifted[i][W-1]}} & POLY);
    end
  end

  assign p = partial[W];

endmodule

// File: rtl/gf_ext_mul.sv
// Quadratic-extension multiplier over GF(2^SUB_W):
// elements hi*X + lo, with X^2 = X + K, where K = CROSS_K.
module gf_ext_mul #(
  parameter int unsigned SUB_W = 6,
  parameter logic [SUB_W-1:0] SUB_POLY = 6'h03,
  parameter logic [SUB_W-1:0] CROSS_K = 6'h21,
  localparam int unsigned FW = 2 * SUB_W
) (
  input  logic [FW-1:0] a,
  input  logic [FW-1:0] b,
  output logic [FW-1:0] p
);

  logic [SUB_W-1:0] aHi, aLo, bHi, bLo;
  logic [SUB_W-1:0] sumProd, lowProd, highProd, crossProd;

  assign aHi = a[FW-1:SUB_W];
  assign aLo = a[SUB_W-1:0];
  assign bHi = b[FW-1:SUB_W];
  assign bLo = b[SUB_W-1:0];

  // (aHi+aLo)(bHi+bLo): middle term of the Karatsuba form
  gf_sub_mul #(.W(SUB_W), .POLY(SUB_POLY)) u_sum (
    .a(aHi ^ aLo), .b(bHi ^ bLo), .p(sumProd)
  );

  gf_sub_mul #(.W(SUB_W), .POLY(SUB_POLY)) u_low (
    .a(aLo), .b(bLo), .p(lowProd)
  );

  gf_sub_mul #(.W(SUB_W), .POLY(SUB_POLY)) u_high (
    .a(aHi), .b(bHi), .p(highProd)
  );

  // X^2 folds back through the fixed constant of the extension polynomial
  gf_sub_mul #(.W(SUB_W), .POLY(SUB_POLY)) u_cross (
    .a(highProd), .b(CROSS_K), .p(crossProd)
  );

  assign p = {sumProd ^ lowProd, crossProd ^ lowProd};

endmodule

// File: rtl/gf_tower_dp.sv
// Datapath: operand product register and power-walk register.
module gf_tower_dp
  import gf_tower_pkg::*;
#(
  parameter int unsigned SUB_W = 6,
  parameter logic [SUB_W-1:0] SUB_POLY = 6'h03,
  parameter logic [SUB_W-1:0] CROSS_K = 6'h21,
  parameter logic [2*SUB_W-1:0] STEP_K = 12'hE01,
  localparam int unsigned FW = 2 * SUB_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  tower_ctl_t    ctl,
  input  logic [FW-1:0] opA,
  input  logic [FW-1:0] opB,
  output logic [FW-1:0] product,
  output logic [FW-1:0] powValue
);

  localparam logic [FW-1:0] ONE = {{(FW-1){1'b0}}, 1'b1};

  logic [FW-1:0] mulRes;
  logic [FW-1:0] stepRes;

  gf_ext_mul #(.SUB_W(SUB_W), .SUB_POLY(SUB_POLY), .CROSS_K(CROSS_K)) u_opMul (
    .a(opA), .b(opB), .p(mulRes)
  );

  gf_ext_mul #(.SUB_W(SUB_W), .SUB_POLY(SUB_POLY), .CROSS_K(CROSS_K)) u_stepMul (
    .a(powValue), .b(STEP_K), .p(stepRes)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      product <= '0;
    end else if (ctl.mulLoad) begin
      product <= mulRes;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      powValue <= ONE;
    end else if (ctl.seqLoad) begin
      powValue <= ONE;
    end else if (ctl.seqStep) begin
      powValue <= stepRes;
    end
  end

endmodule

// File: rtl/gf_tower_ctl.sv
// Control: strobe decode, exponent counter, valid and wrap flags.
module gf_tower_ctl
  import gf_tower_pkg::*;
#(
  parameter int unsigned FW = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          mulValid,
  input  logic          seqStart,
  input  logic          seqEnable,
  output tower_ctl_t    ctl,
  output logic          prodValid,
  output logic [FW-1:0] powIndex,
  output logic          powValid,
  output logic          powWrap
);

  // Group order is 2^FW - 1, so exponents run 0 .. 2^FW - 2
  localparam logic [FW-1:0] IDX_LAST = {{(FW-1){1'b1}}, 1'b0};
  localparam logic [FW-1:0] IDX_ONE  = {{(FW-1){1'b0}}, 1'b1};

  logic atLast;

  assign atLast = (powIndex == IDX_LAST);

  always_comb begin
    ctl.mulLoad = mulValid;
    ctl.seqLoad = seqStart;
    ctl.seqStep = seqEnable & ~seqStart;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prodValid <= 1'b0;
    end else begin
      prodValid <= ctl.mulLoad;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      powIndex <= '0;
      powValid <= 1'b0;
      powWrap  <= 1'b0;
    end else begin
      powValid <= ctl.seqLoad | ctl.seqStep;
      powWrap  <= ctl.seqStep & atLast;
      if (ctl.seqLoad) begin
        powIndex <= '0;
      end else if (ctl.seqStep) begin
        powIndex <= atLast ? '0 : powIndex + IDX_ONE;
      end
    end
  end

endmodule

// File: rtl/gf_tower_mul.sv
// Top: GF(4096) tower-field multiplier with power-sequence stepper.
module gf_tower_mul
  import gf_tower_pkg::*;
#(
  parameter int unsigned SUB_W = 6,
  parameter logic [SUB_W-1:0] SUB_POLY = 6'h03,
  parameter logic [SUB_W-1:0] CROSS_K = 6'h21,
  parameter logic [2*SUB_W-1:0] STEP_K = 12'hE01,
  localparam int unsigned FIELD_W = 2 * SUB_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               mulValid,
  input  logic [FIELD_W-1:0] opA,
  input  logic [FIELD_W-1:0] opB,
  output logic [FIELD_W-1:0] product,
  output logic               prodValid,
  input  logic               seqStart,
  input  logic               seqEnable,
  output logic [FIELD_W-1:0] powValue,
  output logic [FIELD_W-1:0] powIndex,
  output logic               powValid,
  output logic               powWrap
);

  tower_ctl_t ctl;

  gf_tower_ctl #(.FW(FIELD_W)) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .mulValid  (mulValid),
    .seqStart  (seqStart),
    .seqEnable (seqEnable),
    .ctl       (ctl),
    .prodValid (prodValid),
    .powIndex  (powIndex),
    .powValid  (powValid),
    .powWrap   (powWrap)
  );

  gf_tower_dp #(
    .SUB_W    (SUB_W),
    .SUB_POLY (SUB_POLY),
    .CROSS_K  (CROSS_K),
    .STEP_K   (STEP_K)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .opA      (opA),
    .opB      (opB),
    .product  (product),
    .powValue (powValue)
  );

endmodule

// File: rtl/gf_tower_mul_chk.sv
// Property checker for gf_tower_mul, attached by bind below.
module gf_tower_mul_chk #(
  parameter int unsigned FIELD_W = 12,
  parameter logic [FIELD_W-1:0] STEP_K = 12'hE01
) (
  input logic               clk,
  input logic               rstN,
  input logic               mulValid,
  input logic [FIELD_W-1:0] opA,
  input logic [FIELD_W-1:0] opB,
  input logic [FIELD_W-1:0] product,
  input logic               prodValid,
  input logic               seqStart,
  input logic               seqEnable,
  input logic [FIELD_W-1:0] powValue,
  input logic [FIELD_W-1:0] powIndex,
  input logic               powValid,
  input logic               powWrap
);

  localparam logic [FIELD_W-1:0] ONE = {{(FIELD_W-1){1'b0}}, 1'b1};

  p_valid_lag_r3: assert property (@(posedge clk) disable iff (!rstN)
    mulValid |=> prodValid);

  p_hold_product_r3: assert property (@(posedge clk) disable iff (!rstN)
    !mulValid |=> (!prodValid && $stable(product)));

  p_zero_absorb_r4: assert property (@(posedge clk) disable iff (!rstN)
    (mulValid && (opA == '0 || opB == '0)) |=> (product == '0));

  p_identity_r5: assert property (@(posedge clk) disable iff (!rstN)
    (mulValid && opA == ONE) |=> (product == $past(opB)));

  p_start_one_r6: assert property (@(posedge clk) disable iff (!rstN)
    seqStart |=> (powValue == ONE && powIndex == '0 && powValid));

  p_first_root_r7: assert property (@(posedge clk) disable iff (!rstN)
    (seqEnable && !seqStart && powIndex == '0 && powValue == ONE)
      |=> (powValue == STEP_K && powIndex == ONE && powValid));

  p_never_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    powValue != '0);

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!seqStart && !seqEnable)
      |=> ($stable(powValue) && $stable(powIndex) && !powValid && !powWrap));

  p_wrap_at_one_r9: assert property (@(posedge clk) disable iff (!rstN)
    powWrap |-> (powValue == ONE && powIndex == '0 && powValid));

endmodule

bind gf_tower_mul gf_tower_mul_chk #(.FIELD_W(FIELD_W), .STEP_K(STEP_K)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .mulValid  (mulValid),
  .opA       (opA),
  .opB       (opB),
  .product   (product),
  .prodValid (prodValid),
  .seqStart  (seqStart),
  .seqEnable (seqEnable),
  .powValue  (powValue),
  .powIndex  (powIndex),
  .powValid  (powValid),
  .powWrap   (powWrap)
);

// File: tb/gf_tower_mul_tb_top.sv
`timescale 1ns/1ps
module gf_tower_mul_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mulValid = 1'b0;
  logic [11:0] opA = '0;
  logic [11:0] opB = '0;
  logic        seqStart = 1'b0;
  logic        seqEnable = 1'b0;
  logic [11:0] product, powValue, powIndex;
  logic        prodValid, powValid, powWrap;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit cmpOn = 0;

  always #2.5 clk = ~clk;

  gf_tower_mul dut_i (
    .clk(clk), .rstN(rstN), .mulValid(mulValid), .opA(opA), .opB(opB),
    .product(product), .prodValid(prodValid), .seqStart(seqStart),
    .seqEnable(seqEnable), .powValue(powValue), .powIndex(powIndex),
    .powValid(powValid), .powWrap(powWrap)
  );

  // ---------------- behavioural reference ----------------
  function automatic int refMul64(int a, int b);
    int r = 0;
    for (int i = 0; i < 6; i++) begin
      if (((b >> i) & 1) != 0) r = r ^ a;
      a = a << 1;
      if ((a & 64) != 0) a = a ^ 'h43;
    end
    return r & 63;
  endfunction

  function automatic int refMul(int a, int b);
    int ah = (a >> 6) & 63, al = a & 63;
    int bh = (b >> 6) & 63, bl = b & 63;
    int lo = refMul64(al, bl);
    int hi = refMul64(ah ^ al, bh ^ bl) ^ lo;
    int cl = refMul64(refMul64(ah, bh), 'h21) ^ lo;
    return (hi << 6) | cl;
  endfunction

  int eProd = 0, eProdV = 0, ePow = 1, eIdx = 0, ePowV = 0, eWrap = 0;

  always @(posedge clk) begin
    if (rstN) begin
      if (mulValid) eProd <= refMul(opA, opB);
      eProdV <= mulValid;
      if (seqStart) begin
        ePow <= 1; eIdx <= 0; ePowV <= 1; eWrap <= 0;
      end else if (seqEnable) begin
        ePow <= refMul(ePow, 'hE01);
        eIdx <= (eIdx == 4094) ? 0 : eIdx + 1;
        ePowV <= 1;
        eWrap <= (eIdx == 4094);
      end else begin
        ePowV <= 0; eWrap <= 0;
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && cmpOn) begin
      chk("R2", "product", product, eProd);
      chk("R3", "prodValid", prodValid, eProdV);
      chk("R7", "powValue", powValue, ePow);
      chk("R7", "powIndex", powIndex, eIdx);
      chk("R6", "powValid", powValid, ePowV);
      chk("R9", "powWrap", powWrap, eWrap);
    end
  end

  task automatic doMul(int a, int b, output int p);
    @(negedge clk);
    mulValid = 1'b1; opA = a[11:0]; opB = b[11:0];
    @(negedge clk);
    mulValid = 1'b0;
    p = product;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int p1, p2, held, early, a, b;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "product", product, 0);
    chk("R1", "prodValid", prodValid, 0);
    chk("R1", "powValue", powValue, 1);
    chk("R1", "powIndex", powIndex, 0);
    chk("R1", "powValid", powValid, 0);
    chk("R1", "powWrap", powWrap, 0);
    rstN = 1'b1;
    cmpOn = 1;

    // R2 known values: X*X = X + 0x21
    doMul('h040, 'h040, p1); chk("R2", "X*X", p1, 'h061);
    doMul('h025, 'h013, p1); chk("R2", "low-only", p1, refMul('h025, 'h013));
    // R4 zero absorbs
    doMul(0, 'h5A3, p1); chk("R4", "0*b", p1, 0);
    doMul('hFFF, 0, p1); chk("R4", "a*0", p1, 0);
    // R3 hold while idle
    held = product;
    repeat (3) @(negedge clk);
    chk("R3", "held product", product, held);
    chk("R3", "prodValid idle", prodValid, 0);
    // R5 identity and commutativity
    doMul(1, 'hABC, p1); chk("R5", "1*b", p1, 'hABC);
    doMul('h7C1, 1, p1); chk("R5", "a*1", p1, 'h7C1);
    for (int i = 0; i < 24; i++) begin
      a = $urandom_range(0, 4095); b = $urandom_range(0, 4095);
      doMul(a, b, p1); doMul(b, a, p2);
      chk("R5", "commute", p2, p1);
    end
    // R2 back-to-back random products
    @(negedge clk);
    for (int i = 0; i < 200; i++) begin
      mulValid = 1'b1;
      opA = 12'($urandom_range(0, 4095));
      opB = 12'($urandom_range(0, 4095));
      @(negedge clk);
    end
    mulValid = 1'b0;

    // R6 start wins over enable
    seqStart = 1'b1; seqEnable = 1'b1;
    @(negedge clk);
    seqStart = 1'b0; seqEnable = 1'b0;
    chk("R6", "start value", powValue, 1);
    chk("R6", "start index", powIndex, 0);
    chk("R6", "start valid", powValid, 1);
    // R7 first step
    seqEnable = 1'b1;
    @(negedge clk);
    seqEnable = 1'b0;
    chk("R7", "first root", powValue, 'hE01);
    chk("R7", "first index", powIndex, 1);
    // R8 idle hold with gaps
    repeat (3) @(negedge clk);
    chk("R8", "held value", powValue, 'hE01);
    chk("R8", "held index", powIndex, 1);
    chk("R8", "valid low", powValid, 0);
    for (int i = 0; i < 20; i++) begin
      seqEnable = (i % 3) != 0;
      mulValid = (i % 2) == 0;
      opA = 12'(i * 97); opB = 12'(i * 31 + 5);
      @(negedge clk);
    end
    seqEnable = 1'b0; mulValid = 1'b0;

    // R9 full walk
    seqStart = 1'b1;
    @(negedge clk);
    seqStart = 1'b0; seqEnable = 1'b1;
    early = 0;
    for (int k = 1; k <= 4095; k++) begin
      @(negedge clk);
      if (k < 4095) begin
        if (powValue == 12'h001) early++;
        if (powWrap) early++;
      end else begin
        seqEnable = 1'b0;
        chk("R9", "wrap value", powValue, 1);
        chk("R9", "wrap index", powIndex, 0);
        chk("R9", "wrap flag", powWrap, 1);
      end
    end
    chk("R9", "early returns", early, 0);
    @(negedge clk);
    chk("R9", "wrap one cycle", powWrap, 0);
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule